// File: doc/BRIEF.md
# Subtract-and-Branch Single-Instruction Processor Core

This block is a small multi-cycle processor whose only instruction subtracts one memory word from another and branches on the sign of the result. Code and data share one word-addressed memory that sits outside the core and is reached through a single synchronous port. The port carries one read or one write per cycle, and read data returns on the cycle after the address. Each instruction is three consecutive words: a source address, a destination address and a branch target. The core forms `mem[dst] - mem[src]` in 16-bit two's complement and stores the difference at the destination. It then loads the target into the program counter when the difference is zero or negative and the target is nonzero. In every other case it steps forward by three words.

The program counter lives in a core register and is also mirrored into memory word 0 at the end of every instruction. A program can therefore read its own position. When the core fetches at a program counter where a whole instruction no longer fits in memory, it stops for good and raises `halted`. A synchronous reset restarts it at `start_addr`.

The controller is a state machine with eight named states: `ST_FETCH_A`, `ST_FETCH_B`, `ST_FETCH_C`, `ST_READ_A`, `ST_READ_B`, `ST_WRITE_B`, `ST_UPDATE_PC` and `ST_HALT`. Its transitions are:
- FETCH_A goes to FETCH_B when the program counter is in range, and to HALT otherwise.
- FETCH_B, FETCH_C, READ_A, READ_B and WRITE_B each step to the next state in that order.
- WRITE_B goes to UPDATE_PC, and UPDATE_PC returns to FETCH_A.
- HALT stays in HALT.

Top module: `subleq_core`

## Requirements
- R1: An instruction is taken from the three words at addresses pc, pc+1 and pc+2, read in that order as source address, destination address and branch target. Operand addresses use their low ADDR_W bits.
- R2: The core writes `(mem[dst] - mem[src]) mod 65536` to address dst.
- R3: When the difference is zero or negative and the target word is nonzero, the next program counter is the target.
- R4: When the difference is positive, or when the target word is zero, the next program counter is pc+3. A zero target never branches, even after a negative or zero difference.
- R5: Words are signed 16-bit values: a word with bit 15 set (0x8000 to 0xFFFF) is negative. For example, 0x7FFF - 0xFFFF gives 0x8000, which counts as negative. Likewise 0x8000 - 1 gives 0x7FFF, which counts as positive.
- R6: After each instruction, memory word 0 holds the next program counter. This write comes after the destination write, so it wins when dst is 0.
- R7: When a fetch begins with pc greater than 2^ADDR_W - 3, the core raises `halted` one cycle later. From then on `halted` stays high and the core makes no memory access until reset.
- R8: Each instruction takes exactly 7 cycles with one access per cycle, in this order:
  - read pc, read pc+1, read pc+2 (fetch);
  - read src, read dst;
  - write dst, write word 0.
  
  Read data is expected on the cycle after the address. A read and a write never occur in the same cycle.
- R9: While `rst` is high at a clock edge, the state returns to fetch and pc is loaded from `start_addr`. The first cycle after reset therefore reads address `start_addr` when it is in range, and `halted` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | DATA_W | Program counter loaded at reset |
| halted | output | 1 | High once the core has stopped |
| mem_addr | output | ADDR_W | Memory word address |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data from the access of the previous cycle |

## Verification
The bench builds the core with ADDR_W = 6 and DATA_W = 16, giving a 64-word memory whose last legal instruction start is 61. At that size, random words used as branch targets often land past the end of memory, so halting is reached in most random programs. Both boundary starts, 61 (still runs) and 62 (halts at once), can be exercised directly. The 16-bit width keeps the signed wrap points 0x7FFF and 0x8000 at their natural values, so the directed programs can hit them exactly.

// File: rtl/subleq_pkg.sv
package subleq_pkg;

    typedef enum logic [2:0] {
        ST_FETCH_A,
        ST_FETCH_B,
        ST_FETCH_C,
        ST_READ_A,
        ST_READ_B,
        ST_WRITE_B,
        ST_UPDATE_PC,
        ST_HALT
    } state_t;

endpackage

// File: rtl/subleq_fsm.sv
module subleq_fsm
    import subleq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   in_range,
    output state_t state
);

    state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH_A;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_A:   state_nx = in_range ? ST_FETCH_B : ST_HALT;
            ST_FETCH_B:   state_nx = ST_FETCH_C;
            ST_FETCH_C:   state_nx = ST_READ_A;
            ST_READ_A:    state_nx = ST_READ_B;
            ST_READ_B:    state_nx = ST_WRITE_B;
            ST_WRITE_B:   state_nx = ST_UPDATE_PC;
            ST_UPDATE_PC: state_nx = ST_FETCH_A;
            ST_HALT:      state_nx = ST_HALT;
        endcase
    end

endmodule

// File: rtl/subleq_alu.sv
module subleq_alu #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    input  logic [DATA_W-1:0] target,
    input  logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] diff,
    output logic [DATA_W-1:0] next_pc
);

    localparam logic [DATA_W-1:0] STEP = DATA_W'(3);

    logic not_pos;

    always_comb begin
        diff    = minuend - subtrahend;
        not_pos = diff[DATA_W-1] || (diff == '0);
        next_pc = (not_pos && (target != '0)) ? target : pc + STEP;
    end

endmodule

// File: rtl/subleq_core.sv
module subleq_core
    import subleq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] start_addr,
    output logic              halted,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int                MEM_WORDS = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] LAST_PC   = DATA_W'(MEM_WORDS - 3);
    localparam logic [ADDR_W-1:0] PC_WORD   = '0;

    state_t            state;
    logic [DATA_W-1:0] pc;
    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] op_c;
    logic [DATA_W-1:0] val_a;
    logic [DATA_W-1:0] diff;
    logic [DATA_W-1:0] next_pc;
    logic [DATA_W-1:0] next_pc_q;
    logic [ADDR_W-1:0] pc_lo;
    logic              in_range;

    assign in_range = (pc <= LAST_PC);
    assign pc_lo    = pc[ADDR_W-1:0];

    subleq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_range (in_range),
        .state    (state)
    );

    subleq_alu #(.DATA_W(DATA_W)) u_alu (
        .minuend    (mem_rdata),
        .subtrahend (val_a),
        .target     (op_c),
        .pc         (pc),
        .diff       (diff),
        .next_pc    (next_pc)
    );

    // Operand capture: each read returns one cycle after its address
    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= start_addr;
        end else begin
            unique case (state)
                ST_FETCH_B:   op_a      <= mem_rdata;
                ST_FETCH_C:   op_b      <= mem_rdata;
                ST_READ_A:    op_c      <= mem_rdata;
                ST_READ_B:    val_a     <= mem_rdata;
                ST_WRITE_B:   next_pc_q <= next_pc;
                ST_UPDATE_PC: pc        <= next_pc_q;
                default:      ;
            endcase
        end
    end

    // Memory port and status outputs decoded from the state
    always_comb begin
        mem_addr  = '0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        halted    = 1'b0;
        unique case (state)
            ST_FETCH_A: begin
                mem_addr = pc_lo;
                mem_re   = in_range;
            end
            ST_FETCH_B: begin
                mem_addr = pc_lo + ADDR_W'(1);
                mem_re   = 1'b1;
            end
            ST_FETCH_C: begin
                mem_addr = pc_lo + ADDR_W'(2);
                mem_re   = 1'b1;
            end
            ST_READ_A: begin
                mem_addr = op_a[ADDR_W-1:0];
                mem_re   = 1'b1;
            end
            ST_READ_B: begin
                mem_addr = op_b[ADDR_W-1:0];
                mem_re   = 1'b1;
            end
            ST_WRITE_B: begin
                mem_addr  = op_b[ADDR_W-1:0];
                mem_we    = 1'b1;
                mem_wdata = diff;
            end
            ST_UPDATE_PC: begin
                mem_addr  = PC_WORD;
                mem_we    = 1'b1;
                mem_wdata = next_pc_q;
            end
            ST_HALT: halted = 1'b1;
        endcase
    end

endmodule

// File: rtl/subleq_checker.sv
module subleq_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] start_addr,
    input logic              halted,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we
);

    localparam logic [DATA_W-1:0] LAST_PC = DATA_W'((1 << ADDR_W) - 3);

    AST_NO_READ_WRITE_MIX: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R8

    AST_WRITE_PAIR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |=> !mem_we); // R8

    AST_PC_MIRROR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we) |=> (mem_we && mem_addr == '0)); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted); // R7

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_re && !mem_we)); // R7

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ($past(start_addr) <= LAST_PC))
            |-> (mem_re && mem_addr == $past(start_addr[ADDR_W-1:0]))); // R9

endmodule

bind subleq_core subleq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_addr (start_addr),
    .halted     (halted),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we)
);

// File: tb/tb_subleq_core.sv
module tb_subleq_core;

    localparam int AW   = 6;
    localparam int DW   = 16;
    localparam int MW   = 1 << AW;
    localparam int LAST = MW - 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] start_addr = '0;
    logic          halted;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          load = 1'b0;

    logic [DW-1:0] img   [MW];
    logic [DW-1:0] ref_m [MW];
    logic [DW-1:0] mem   [MW];

    logic [AW-1:0] tr_addr [7];
    logic          tr_re   [7];
    logic          tr_we   [7];

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    subleq_core #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk        (clk),
        .rst        (rst),
        .start_addr (start_addr),
        .halted     (halted),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata)
    );

    always @(posedge clk) begin
        if (load) mem <= img;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Reference interpreter following R1-style rules independently
    task automatic ref_run(input logic [DW-1:0] start, input int cap,
                           output int n, output bit h);
        logic [DW-1:0] pc, a, b, c, d, npc;
        pc = start; n = 0; h = 1'b0;
        while (n < cap) begin
            if (pc > DW'(LAST)) begin h = 1'b1; break; end
            a = ref_m[pc]; b = ref_m[pc + 1]; c = ref_m[pc + 2];
            d = ref_m[b[AW-1:0]] - ref_m[a[AW-1:0]];
            ref_m[b[AW-1:0]] = d;
            npc = ((d[DW-1] || d == '0) && c != '0) ? c : pc + DW'(3);
            ref_m[0] = npc;
            pc = npc;
            n++;
        end
    endtask

    task automatic run_prog(input logic [DW-1:0] start, input int cap, input string tag);
        int n, edges, bad;
        bit h;
        ref_m = img;
        ref_run(start, cap, n, h);
        @(negedge clk);
        rst = 1'b1; load = 1'b1; start_addr = start;
        @(negedge clk);
        load = 1'b0;
        chk("R9", {tag, " halted in reset"}, 32'(halted), 32'd0);
        chk("R9", {tag, " no write in reset"}, 32'(mem_we), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        chk("R9", {tag, " first read strobe"}, 32'(mem_re), (start <= DW'(LAST)) ? 32'd1 : 32'd0);
        if (start <= DW'(LAST))
            chk("R9", {tag, " first address"}, 32'(mem_addr), 32'(start[AW-1:0]));
        edges = h ? 7 * n : 7 * cap;
        for (int cy = 0; cy < edges; cy++) begin
            if (cy < 7) begin
                tr_addr[cy] = mem_addr; tr_re[cy] = mem_re; tr_we[cy] = mem_we;
            end
            @(negedge clk);
        end
        chk("R8", {tag, " not halted at instruction boundary"}, 32'(halted), 32'd0);
        if (h) begin
            @(negedge clk);
            chk("R7", {tag, " halted after out-of-range fetch"}, 32'(halted), 32'd1);
            repeat (3) @(negedge clk);
            chk("R7", {tag, " halt sticky"}, 32'(halted), 32'd1);
            chk("R7", {tag, " silent when halted"}, 32'({mem_re, mem_we}), 32'd0);
        end
        bad = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== ref_m[i]) bad++;
        chk("R2", {tag, " memory mismatches"}, 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R8 watchdog act=timeout exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed_val;
        seed_val = $urandom(32'd2024);

        // Directed program: fall-through, branch, clear, signed wrap, halt
        for (int i = 0; i < MW; i++) img[i] = '0;
        img[3]  = 16'd40; img[4]  = 16'd41; img[5]  = 16'd20;
        img[6]  = 16'd42; img[7]  = 16'd43; img[8]  = 16'd12;
        img[12] = 16'd44; img[13] = 16'd44; img[14] = 16'd0;
        img[15] = 16'd45; img[16] = 16'd46; img[17] = 16'd24;
        img[24] = 16'd47; img[25] = 16'd48; img[26] = 16'd30;
        img[27] = 16'd49; img[28] = 16'd49; img[29] = 16'd63;
        img[40] = 16'd3;  img[41] = 16'd10;
        img[42] = 16'd9;  img[43] = 16'd5;
        img[44] = 16'h1234;
        img[45] = 16'hFFFF; img[46] = 16'h7FFF;
        img[47] = 16'd1;    img[48] = 16'h8000;
        img[49] = 16'd7;
        run_prog(16'd3, 50, "dir1");
        chk("R1", "trace addr0", 32'(tr_addr[0]), 32'd3);
        chk("R1", "trace addr1", 32'(tr_addr[1]), 32'd4);
        chk("R1", "trace addr2", 32'(tr_addr[2]), 32'd5);
        chk("R8", "trace src read", 32'(tr_addr[3]), 32'd40);
        chk("R8", "trace dst read", 32'(tr_addr[4]), 32'd41);
        chk("R8", "trace dst write", 32'({tr_addr[5], tr_we[5], tr_re[5]}), {24'd0, 6'd41, 2'b10});
        chk("R8", "trace pc write", 32'({tr_addr[6], tr_we[6], tr_re[6]}), {24'd0, 6'd0, 2'b10});
        chk("R8", "trace reads strobed", 32'({tr_re[0], tr_re[1], tr_re[2], tr_re[3], tr_re[4]}), 32'h1F);
        chk("R4", "positive falls through, result", 32'(mem[41]), 32'd7);
        chk("R2", "negative difference wraps", 32'(mem[43]), 32'hFFFC);
        chk("R4", "zero target with zero result", 32'(mem[44]), 32'd0);
        chk("R5", "0x7FFF minus -1", 32'(mem[46]), 32'h8000);
        chk("R5", "0x8000 minus 1", 32'(mem[48]), 32'h7FFF);
        chk("R3", "final pc mirror after branches", 32'(mem[0]), 32'd63);

        // Boundary start 61 runs, falls through to 64 and halts
        for (int i = 0; i < MW; i++) img[i] = '0;
        img[61] = 16'd50; img[62] = 16'd51; img[63] = 16'd0;
        img[50] = 16'd5;  img[51] = 16'd5;
        run_prog(16'd61, 10, "edge61");
        chk("R4", "last legal start executes", 32'(mem[51]), 32'd0);
        chk("R6", "pc mirror after fall-through", 32'(mem[0]), 32'd64);

        // Start 62 halts at once, memory untouched
        img[0] = 16'hABCD;
        run_prog(16'd62, 10, "edge62");
        chk("R7", "no write before halt", 32'(mem[0]), 32'hABCD);

        // Destination word 0 is overwritten by the pc mirror
        for (int i = 0; i < MW; i++) img[i] = '0;
        img[10] = 16'd50; img[11] = 16'd0;  img[12] = 16'd0;
        img[13] = 16'd52; img[14] = 16'd52; img[15] = 16'd62;
        img[50] = 16'd100;
        run_prog(16'd10, 10, "dst0");
        chk("R6", "mirror wins over dst 0", 32'(mem[0]), 32'd62);

        // Random programs against the reference interpreter
        for (int r = 0; r < 25; r++) begin
            for (int i = 0; i < MW; i++)
                img[i] = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 70));
            run_prog(16'($urandom_range(0, 63)), 120, $sformatf("rnd%0d", r));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule